// File: doc/BRIEF.md
# Dual-clock FIFO with almost-empty and half-full flags

This block is a first-in first-out buffer that moves 36-bit words from a write clock domain to an unrelated read clock domain. The storage is a power-of-two RAM. Both pointers cross between the domains as Gray code through two-flop synchronizers. Two active-low flags are built from the word count: an almost-empty flag with an offset `n`, and a half-full flag.

Three inputs are captured while reset is held and stay fixed after it. The first picks the read style. In standard reads, a word reaches the output only after a read request. In fall-through reads, an output register shows the oldest word unasked, and that register adds one word of capacity. The second input picks how the almost-empty flag is timed. The third sets the offset `n`.

In both read styles, the half-full flag is pulled low from the write side and released from the read side. In the cross-domain almost-empty style, the almost-empty flag is pulled low from the read side and released from the write side. In the read-clocked style, the almost-empty flag is a plain register in the read domain.

Top module: `dcfifo_flags`

## Requirements
- R1: While `rst_ni` is low: `empty_o`=1, `full_o`=0, `pae_no`=1, `hf_no`=1.
- R2: Standard reads (`fwft_i`=0 at reset): the oldest word appears on `rdata_o` at the read-clock edge where `ren_i`=1 and `empty_o`=0. `rdata_o` holds its value between reads.
- R3: Fall-through reads (`fwft_i`=1 at reset): with no read request, the first word written appears on `rdata_o` and `empty_o` falls. Each read-clock edge with `ren_i`=1 shows the next word in write order.
- R4: With `DEPTH`=2^`AW`, `full_o` rises when the buffer holds `DEPTH` words (standard) or `DEPTH`+1 words (fall-through). A write while `full_o`=1 stores nothing, and later reads never return that word.
- R5: A read while `empty_o`=1 changes neither the read position nor the data later returned.
- R6: Standard reads: `pae_no`=0 at `n` or fewer stored words, and 1 at `n`+1 or more.
- R7: Fall-through reads: `pae_no`=0 at `n`+1 or fewer words, and 1 at `n`+2 or more.
- R8: With `ae_sync_i`=0 at reset (cross-domain style), `pae_no` falls at the read-clock edge whose read brings the count down to the threshold, and rises at the write-clock edge whose write takes the count above it.
- R9: With `ae_sync_i`=1 at reset, `pae_no` changes only on read-clock edges. A write is reflected only after the write pointer has passed two read-clock flops.
- R10: Standard reads: `hf_no`=0 at `DEPTH`/2+1 words or more, and 1 at `DEPTH`/2 or fewer.
- R11: Fall-through reads: `hf_no`=0 at `DEPTH`/2+2 words or more, and 1 at `DEPTH`/2+1 or fewer.
- R12: `hf_no` falls at the write-clock edge whose write reaches the threshold, and rises at the read-clock edge whose read drops the count below it.
- R13: `fwft_i`, `ae_sync_i` and `ae_off_i` are sampled only while reset is held. Changing them later has no effect on the flags or the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, active low, asynchronous |
| fwft_i | input | 1 | Read style captured at reset: 1 fall-through, 0 standard |
| ae_sync_i | input | 1 | Almost-empty timing captured at reset: 1 read-clocked, 0 cross-domain |
| ae_off_i | input | AW | Almost-empty offset `n`, captured at reset |
| wen_i | input | 1 | Write request, sampled on `wclk_i` |
| wdata_i | input | DW | Write data |
| full_o | output | 1 | Buffer full, write domain |
| ren_i | input | 1 | Read request, sampled on `rclk_i` |
| rdata_o | output | DW | Read data |
| empty_o | output | 1 | No word available, read domain |
| pae_no | output | 1 | Almost-empty flag, active low |
| hf_no | output | 1 | Half-full flag, active low |

## Verification
The bench builds the block with `AW`=4 and `DW`=36, giving a 16-word RAM. At that size, full, half-full at 9 or 10 words, and the fall-through capacity of 17 are all reached with a few dozen writes. The offset is 3, so both almost-empty boundaries of each read style fall inside a short fill-and-drain pattern. A 50 MHz write clock against a slower, unrelated read clock means the bench can sample one domain before any edge of the other could have moved a flag. That is what separates the cross-domain almost-empty timing from the read-clocked one.

// File: rtl/dcff_pkg.sv
package dcff_pkg;
  typedef enum logic {RD_STD = 1'b0, RD_FWFT = 1'b1} rd_mode_e;
  typedef enum logic {AE_XDOM = 1'b0, AE_RCLK = 1'b1} ae_mode_e;

  function automatic logic [31:0] bin2gray(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcff_sync2.sv
module dcff_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
endmodule

// File: rtl/dcff_mem.sv
module dcff_mem #(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i)
    if (we_i) mem_q[waddr_i] <= wdata_i;

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcff_xflag.sv
// Flag set from one clock, cleared from another: toggle pair, each side
// sees the other's toggle through a two-flop synchronizer.
module dcff_xflag (
  input  logic set_clk_i,
  input  logic clr_clk_i,
  input  logic rst_ni,
  input  logic set_req_i,
  input  logic clr_req_i,
  output logic flag_o
);
  logic set_tog_q, clr_tog_q, set_tog_s, clr_tog_s;
  logic seen_set_a, seen_set_b;

  dcff_sync2 #(.W(1)) u_clr2set (
    .clk_i(set_clk_i), .rst_ni(rst_ni), .d_i(clr_tog_q), .q_o(clr_tog_s)
  );
  dcff_sync2 #(.W(1)) u_set2clr (
    .clk_i(clr_clk_i), .rst_ni(rst_ni), .d_i(set_tog_q), .q_o(set_tog_s)
  );

  assign seen_set_a = set_tog_q ^ clr_tog_s;
  assign seen_set_b = set_tog_s ^ clr_tog_q;

  always_ff @(posedge set_clk_i or negedge rst_ni)
    if (!rst_ni)                      set_tog_q <= 1'b0;
    else if (!seen_set_a && set_req_i) set_tog_q <= ~set_tog_q;

  always_ff @(posedge clr_clk_i or negedge rst_ni)
    if (!rst_ni)                     clr_tog_q <= 1'b0;
    else if (seen_set_b && clr_req_i) clr_tog_q <= ~clr_tog_q;

  assign flag_o = set_tog_q ^ clr_tog_q;
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags
  import dcff_pkg::*;
#(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          ae_sync_i,
  input  logic [AW-1:0] ae_off_i,
  input  logic          wen_i,
  input  logic [DW-1:0] wdata_i,
  output logic          full_o,
  input  logic          ren_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          pae_no,
  output logic          hf_no
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HF_BASE = PW'(DEPTH / 2 + 1);

  // ---------------- write domain ----------------
  logic          wlive_q;
  rd_mode_e      wmode_q;
  logic [AW-1:0] woff_q;
  logic [PW-1:0] wbin_q, wbin_nx, wgray_q;
  logic [PW-1:0] fetch_gs, cons_gs, fetch_sb, cons_sb;
  logic [PW-1:0] wcnt_nx, wthr, whf_thr;
  logic          wr_go;

  always_ff @(posedge wclk_i or negedge rst_ni)
    if (!rst_ni) wlive_q <= 1'b0;
    else         wlive_q <= 1'b1;

  // captured while reset holds the domain idle
  always_ff @(posedge wclk_i)
    if (!wlive_q) begin
      wmode_q <= rd_mode_e'(fwft_i);
      woff_q  <= ae_off_i;
    end

  dcff_sync2 #(.W(2 * PW)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni),
    .d_i({rfetch_gray_q, rcons_gray_q}), .q_o({fetch_gs, cons_gs})
  );

  assign fetch_sb = PW'(gray2bin(32'(fetch_gs)));
  assign cons_sb  = PW'(gray2bin(32'(cons_gs)));
  assign full_o   = (wbin_q - fetch_sb) == DEPTH_P;
  assign wr_go    = wen_i && !full_o;
  assign wbin_nx  = wbin_q + PW'(wr_go);

  always_ff @(posedge wclk_i or negedge rst_ni)
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= PW'(bin2gray(32'(wbin_nx)));
    end

  assign wcnt_nx = wbin_nx - cons_sb;
  assign wthr    = PW'(woff_q) + PW'(wmode_q == RD_FWFT);
  assign whf_thr = HF_BASE + PW'(wmode_q == RD_FWFT);

  // ---------------- storage ----------------
  logic [DW-1:0] mem_rd;
  logic [PW-1:0] fetch_q;

  dcff_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (wr_go),
    .waddr_i(wbin_q[AW-1:0]),
    .wdata_i(wdata_i),
    .raddr_i(fetch_q[AW-1:0]),
    .rdata_o(mem_rd)
  );

  // ---------------- read domain ----------------
  logic          rlive_q;
  rd_mode_e      rmode_q;
  ae_mode_e      aemode_q;
  logic [AW-1:0] roff_q;
  logic [PW-1:0] cons_q, fetch_nx, cons_nx;
  logic [PW-1:0] rfetch_gray_q, rcons_gray_q;
  logic [PW-1:0] wgray_s, wbin_s, rcnt_nx, rthr, rhf_thr;
  logic          ovld_q, ram_ne, ld, pop, ae_rclk_nq;

  always_ff @(posedge rclk_i or negedge rst_ni)
    if (!rst_ni) rlive_q <= 1'b0;
    else         rlive_q <= 1'b1;

  always_ff @(posedge rclk_i)
    if (!rlive_q) begin
      rmode_q  <= rd_mode_e'(fwft_i);
      aemode_q <= ae_mode_e'(ae_sync_i);
      roff_q   <= ae_off_i;
    end

  dcff_sync2 #(.W(PW)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray_q), .q_o(wgray_s)
  );

  assign wbin_s = PW'(gray2bin(32'(wgray_s)));
  assign ram_ne = wbin_s != fetch_q;

  always_comb begin
    if (rmode_q == RD_FWFT) begin
      pop = ovld_q && ren_i;
      ld  = ram_ne && (!ovld_q || pop);
    end else begin
      ld  = ren_i && ram_ne;
      pop = ld;
    end
  end

  assign fetch_nx = fetch_q + PW'(ld);
  assign cons_nx  = cons_q + PW'(pop);

  always_ff @(posedge rclk_i or negedge rst_ni)
    if (!rst_ni) begin
      fetch_q       <= '0;
      cons_q        <= '0;
      rfetch_gray_q <= '0;
      rcons_gray_q  <= '0;
      ovld_q        <= 1'b0;
      rdata_o       <= '0;
    end else begin
      fetch_q       <= fetch_nx;
      cons_q        <= cons_nx;
      rfetch_gray_q <= PW'(bin2gray(32'(fetch_nx)));
      rcons_gray_q  <= PW'(bin2gray(32'(cons_nx)));
      ovld_q        <= (rmode_q == RD_FWFT) && (ld || (ovld_q && !pop));
      if (ld) rdata_o <= mem_rd;
    end

  assign empty_o = (rmode_q == RD_FWFT) ? !ovld_q : !ram_ne;
  assign rcnt_nx = wbin_s - cons_nx;
  assign rthr    = PW'(roff_q) + PW'(rmode_q == RD_FWFT);
  assign rhf_thr = HF_BASE + PW'(rmode_q == RD_FWFT);

  // ---------------- flags ----------------
  logic ae_flag, hf_flag;

  always_ff @(posedge rclk_i or negedge rst_ni)
    if (!rst_ni) ae_rclk_nq <= 1'b1;
    else         ae_rclk_nq <= !(rcnt_nx <= rthr);

  dcff_xflag u_ae_x (
    .set_clk_i(rclk_i), .clr_clk_i(wclk_i), .rst_ni(rst_ni),
    .set_req_i(rcnt_nx <= rthr), .clr_req_i(wcnt_nx > wthr),
    .flag_o(ae_flag)
  );

  dcff_xflag u_hf_x (
    .set_clk_i(wclk_i), .clr_clk_i(rclk_i), .rst_ni(rst_ni),
    .set_req_i(wcnt_nx >= whf_thr), .clr_req_i(rcnt_nx < rhf_thr),
    .flag_o(hf_flag)
  );

  assign pae_no = (aemode_q == AE_RCLK) ? ae_rclk_nq : !ae_flag;
  assign hf_no  = !hf_flag;

  // ---------------- assertions ----------------
  a_r4_no_write_when_full: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o && wen_i |=> wbin_q == $past(wbin_q));

  a_r4_fill_bound: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wbin_q - fetch_sb) <= DEPTH_P);

  a_r4_gray_one_step: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);

  a_r5_no_read_when_empty: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_o && ren_i |=> cons_q == $past(cons_q));

  a_r3_fwft_hold: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rmode_q == RD_FWFT) && !empty_o && !ren_i |=> !empty_o && $stable(rdata_o));

  a_r2_std_hold: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rmode_q == RD_STD) && !ren_i |=> $stable(rdata_o));
endmodule

// File: tb/tb_dcfifo_flags.sv
module tb_dcfifo_flags;
  localparam int DW = 36;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          wclk_i = 1'b0, rclk_i = 1'b0, rst_ni = 1'b0;
  logic          fwft_i = 1'b0, ae_sync_i = 1'b0;
  logic [AW-1:0] ae_off_i = '0;
  logic          wen_i = 1'b0, ren_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic          full_o, empty_o, pae_no, hf_no;
  logic [DW-1:0] rdata_o;

  always #10 wclk_i = ~wclk_i;  // 50 MHz
  always #17 rclk_i = ~rclk_i;

  dcfifo_flags #(.DW(DW), .AW(AW)) dut (
    .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni),
    .fwft_i(fwft_i), .ae_sync_i(ae_sync_i), .ae_off_i(ae_off_i),
    .wen_i(wen_i), .wdata_i(wdata_i), .full_o(full_o),
    .ren_i(ren_i), .rdata_o(rdata_o), .empty_o(empty_o),
    .pae_no(pae_no), .hf_no(hf_no)
  );

  int n_chk = 0, n_bad = 0;
  int cap = DEPTH;
  logic [DW-1:0] seq = 36'h5_0000_0000;
  logic [DW-1:0] model_q[$];

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge rclk_i);
    repeat (6) @(negedge wclk_i);
  endtask

  task automatic do_reset(logic fw, logic aes, logic [AW-1:0] off);
    rst_ni = 1'b0;
    fwft_i = fw; ae_sync_i = aes; ae_off_i = off;
    model_q.delete();
    cap = fw ? DEPTH + 1 : DEPTH;
    repeat (6) @(negedge wclk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge wclk_i);
    // R13: later changes of the captured inputs must not matter
    fwft_i = ~fw; ae_sync_i = ~aes; ae_off_i = AW'(10);
    settle();
  endtask

  task automatic do_write(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk_i);
      wen_i = 1'b1; wdata_i = seq;
      if (model_q.size() < cap) model_q.push_back(seq);
      seq++;
    end
    @(negedge wclk_i);
    wen_i = 1'b0;
  endtask

  // standard-style read: data checked after the edge
  task automatic do_read(int n);
    for (int i = 0; i < n; i++) begin
      logic had;
      @(negedge rclk_i);
      had = !empty_o;
      chk("R5 empty matches model", DW'(empty_o), DW'(model_q.size() == 0));
      ren_i = 1'b1;
      @(negedge rclk_i);
      ren_i = 1'b0;
      if (had) chk("R2 read order", rdata_o, model_q.pop_front());
    end
  endtask

  // fall-through read: data checked before the edge
  task automatic do_read_ft(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk_i);
      if (model_q.size() > 0) chk("R3 fall-through word", rdata_o, model_q[0]);
      ren_i = 1'b1;
      @(negedge rclk_i);
      ren_i = 1'b0;
      if (model_q.size() > 0) void'(model_q.pop_front());
    end
  endtask

  typedef struct packed {
    logic       rd;
    logic [5:0] num;
    logic       pae;
    logic       hf;
    logic       emp;
    logic       full;
  } vec_t;

  // standard reads, offset 3, 16 words
  localparam int NV = 11;
  localparam vec_t VEC[NV] = '{
    '{1'b0, 6'd3,  1'b0, 1'b1, 1'b0, 1'b0},  // 3 words
    '{1'b0, 6'd1,  1'b1, 1'b1, 1'b0, 1'b0},  // 4: high though offset input now 10 (R13)
    '{1'b0, 6'd4,  1'b1, 1'b1, 1'b0, 1'b0},  // 8
    '{1'b0, 6'd1,  1'b1, 1'b0, 1'b0, 1'b0},  // 9
    '{1'b1, 6'd1,  1'b1, 1'b1, 1'b0, 1'b0},  // 8
    '{1'b0, 6'd8,  1'b1, 1'b0, 1'b0, 1'b1},  // 16
    '{1'b0, 6'd2,  1'b1, 1'b0, 1'b0, 1'b1},  // still 16, writes dropped
    '{1'b1, 6'd12, 1'b1, 1'b1, 1'b0, 1'b0},  // 4
    '{1'b1, 6'd1,  1'b0, 1'b1, 1'b0, 1'b0},  // 3
    '{1'b1, 6'd3,  1'b0, 1'b1, 1'b1, 1'b0},  // 0
    '{1'b1, 6'd2,  1'b0, 1'b1, 1'b1, 1'b0}   // reads while empty ignored
  };

  initial begin
    repeat (200000) @(posedge wclk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all): actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (6) @(negedge wclk_i);
    chk("R1 empty", DW'(empty_o), 1);
    chk("R1 full", DW'(full_o), 0);
    chk("R1 pae", DW'(pae_no), 1);
    chk("R1 hf", DW'(hf_no), 1);

    // standard reads, cross-domain almost-empty, offset 3
    do_reset(1'b0, 1'b0, AW'(3));
    chk("R6 pae at 0 words", DW'(pae_no), 0);
    foreach (VEC[i]) begin
      if (VEC[i].rd) do_read(int'(VEC[i].num));
      else           do_write(int'(VEC[i].num));
      settle();
      chk("R6 R13 pae", DW'(pae_no), DW'(VEC[i].pae));
      chk("R10 hf", DW'(hf_no), DW'(VEC[i].hf));
      chk("R5 empty", DW'(empty_o), DW'(VEC[i].emp));
      chk("R4 full", DW'(full_o), DW'(VEC[i].full));
    end

    // R8: cross-domain edges of the almost-empty flag
    do_write(4); settle();
    chk("R8 pae high at 4", DW'(pae_no), 1);
    do_read(1);
    chk("R8 pae low on read edge", DW'(pae_no), 0);
    settle();
    do_write(1);
    chk("R8 pae high on write edge", DW'(pae_no), 1);
    settle();
    // R12: half-full edges
    do_write(4); settle();
    chk("R12 hf high at 8", DW'(hf_no), 1);
    do_write(1);
    chk("R12 hf low on write edge", DW'(hf_no), 0);
    settle();
    do_read(1);
    chk("R12 hf high on read edge", DW'(hf_no), 1);
    settle();
    do_read(8); settle();
    chk("R5 drained", DW'(empty_o), 1);

    // R9: read-clocked almost-empty
    do_reset(1'b0, 1'b1, AW'(3));
    do_write(3); settle();
    chk("R9 pae low at 3", DW'(pae_no), 0);
    do_write(1);
    chk("R9 pae unmoved by write edge", DW'(pae_no), 0);
    settle();
    chk("R9 pae high after sync", DW'(pae_no), 1);
    do_read(1);
    chk("R9 pae low on read edge", DW'(pae_no), 0);
    settle();
    do_read(3); settle();

    // fall-through reads, offset 3
    do_reset(1'b1, 1'b0, AW'(3));
    chk("R3 empty before write", DW'(empty_o), 1);
    do_write(1); settle();
    chk("R3 empty falls unasked", DW'(empty_o), 0);
    chk("R3 first word shown", rdata_o, model_q[0]);
    do_write(3); settle();
    chk("R7 pae low at 4", DW'(pae_no), 0);
    do_write(1); settle();
    chk("R7 pae high at 5", DW'(pae_no), 1);
    do_write(4); settle();
    chk("R11 hf high at 9", DW'(hf_no), 1);
    do_write(1); settle();
    chk("R11 hf low at 10", DW'(hf_no), 0);
    do_write(6); settle();
    chk("R4 not full at 16", DW'(full_o), 0);
    do_write(1); settle();
    chk("R4 full at 17", DW'(full_o), 1);
    do_write(2); settle();
    chk("R4 still full", DW'(full_o), 1);
    do_read_ft(17); settle();
    chk("R5 empty after drain", DW'(empty_o), 1);
    @(negedge rclk_i); ren_i = 1'b1;
    @(negedge rclk_i); ren_i = 1'b0;
    settle();
    chk("R5 read on empty ignored", DW'(empty_o), 1);
    do_write(1); settle();
    chk("R5 next word intact", rdata_o, model_q[0]);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule